// File: doc/BRIEF.md
# Receive Frame Queue with Interrupt/DMA Service Handshake

This block buffers already-decoded CAN frames in a small first-in, first-out queue. Each entry keeps four 32-bit words: a control/status word, the received identifier and two data words. Software or a DMA engine sees only the oldest entry. It reads the entry through a register-style port at fixed word offsets. A frames-available flag stays set while anything is queued.

Reads have no effect on the queue. The consumer releases the oldest entry by writing 1 to the frames-available bit, and the next entry then becomes visible. A mode input selects how the consumer is alerted. With the mode clear, the block raises a maskable interrupt. With the mode set, it raises a DMA request, and the interrupt mask has no effect. At the input, a frame marked as sent by this node is discarded while self-reception is disabled. A full queue discards new frames and records the loss in a sticky overflow bit.

Top module: `rx_frame_queue`

## Requirements
- R1: Flag register at offset 0x00, bit 0 (available) reads 1 exactly while at least one frame is queued.
- R2: Only a write with bit 0 set to offset 0x00 releases the head entry. A write of 0 to that bit, a write to any other offset, or a release while the queue is empty changes nothing.
- R3: Reads at any offset leave the queue contents, order and flags unchanged.
- R4: The head entry's control/status, identifier, data0 and data1 words read at 0x80, 0x84, 0x88 and 0x8C. Frames come out in arrival order, and these offsets read 0 when the queue is empty.
- R5: The identifier word stored is exactly the identifier presented at the input.
- R6: When self_rx_dis is 1, a frame with in_self=1 is discarded and raises no flag, interrupt or request. When self_rx_dis is 0, such a frame is stored like any other.
- R7: The queue holds 6 frames. A frame that arrives while the queue is full is discarded and sets the sticky overflow bit (0x00 bit 2). Writing 1 to bit 2 clears it.
- R8: Warning bit (0x00 bit 1) reads 1 while 5 or more frames are queued.
- R9: irq equals available AND irq_mask while dma_mode is 0. irq is 0 while dma_mode is 1, whatever the mask.
- R10: dma_req equals available while dma_mode is 1. It is 0 for the one cycle after each release write. It is always 0 while dma_mode is 0.
- R11: After reset the queue is empty, all flag bits are 0, and irq and dma_req are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A decoded frame is present this cycle |
| in_cs | input | 32 | Control/status word of the incoming frame |
| in_id | input | 32 | Received identifier word |
| in_d0 | input | 32 | First data word |
| in_d1 | input | 32 | Second data word |
| in_self | input | 1 | Frame was transmitted by this node |
| self_rx_dis | input | 1 | Discard self-transmitted frames |
| dma_mode | input | 1 | 1: alert through DMA request, 0: through interrupt |
| irq_mask | input | 1 | Interrupt enable for the available flag |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Flag register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data (write-1-to-clear bits) |
| irq | output | 1 | Frames-available interrupt |
| dma_req | output | 1 | Frames-available DMA request |

## Verification
The bench fills the queue to six entries and then offers two more frames. A design with an off-by-one full test would accept a seventh frame or lose the sixth, and the stored order would then differ from arrival order. It writes 0 to the release bit, writes 1 at a non-flag offset, and releases an empty queue. A design that decodes the write loosely would advance the head pointer or wrap the count. With two frames queued in DMA mode it checks for the one-cycle gap in the request after a release. A design that holds the request high would let the DMA engine read the old head again. It also checks that the mask has no effect in DMA mode. Self-transmitted frames go in with self-reception disabled and then enabled, so a design that tests the wrong polarity stores frames it should discard.

// File: rtl/rx_frame_queue.sv
module rx_frame_queue #(
  parameter int DW         = 32,
  parameter int AW         = 8,
  parameter int DEPTH      = 6,
  parameter int WARN_LEVEL = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_cs,
  input  logic [DW-1:0] in_id,
  input  logic [DW-1:0] in_d0,
  input  logic [DW-1:0] in_d1,
  input  logic          in_self,
  input  logic          self_rx_dis,
  input  logic          dma_mode,
  input  logic          irq_mask,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          irq,
  output logic          dma_req
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] FLAG_OFS = AW'('h00);
  localparam logic [AW-1:0] CS_OFS   = AW'('h80);
  localparam logic [AW-1:0] ID_OFS   = AW'('h84);
  localparam logic [AW-1:0] D0_OFS   = AW'('h88);
  localparam logic [AW-1:0] D1_OFS   = AW'('h8C);
  localparam logic [PW-1:0] LAST     = PW'(DEPTH - 1);

  logic [DW-1:0] mem_cs [DEPTH];
  logic [DW-1:0] mem_id [DEPTH];
  logic [DW-1:0] mem_d0 [DEPTH];
  logic [DW-1:0] mem_d1 [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          ovf, rel_q;

  wire empty   = (cnt == '0);
  wire full    = (cnt == CW'(DEPTH));
  wire accept  = in_valid & ~(in_self & self_rx_dis);
  wire push    = accept & ~full;
  wire flag_wr = wr_en & (wr_addr == FLAG_OFS);
  wire pop     = flag_wr & wr_data[0] & ~empty;
  wire avail   = ~empty;
  wire warn    = (cnt >= CW'(WARN_LEVEL));

  logic unused_wr;
  assign unused_wr = ^{wr_data[DW-1:3], wr_data[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      ovf   <= 1'b0;
      rel_q <= 1'b0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      cnt   <= cnt + CW'(push) - CW'(pop);
      rel_q <= pop;
      if (accept && full)              ovf <= 1'b1;
      else if (flag_wr && wr_data[2])  ovf <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      mem_cs[wp] <= in_cs;
      mem_id[wp] <= in_id;
      mem_d0[wp] <= in_d0;
      mem_d1[wp] <= in_d1;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == FLAG_OFS)
      rd_data = DW'({ovf, warn, avail});
    else if (!empty) begin
      case (rd_addr)
        CS_OFS:  rd_data = mem_cs[rp];
        ID_OFS:  rd_data = mem_id[rp];
        D0_OFS:  rd_data = mem_d0[rp];
        D1_OFS:  rd_data = mem_d1[rp];
        default: rd_data = '0;
      endcase
    end
  end

  assign irq     = avail & irq_mask & ~dma_mode;
  assign dma_req = avail & dma_mode & ~rel_q;

  a_r7_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r7_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !flag_wr) |=> ($stable(cnt) && ovf));
  a_r6_self_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_self && self_rx_dis && !wr_en) |=> $stable(cnt));
  a_r3_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !wr_en) |=> ($stable(cnt) && $stable(rp)));
  a_r2_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !in_valid) |=> (cnt == $past(cnt) - 1'b1));
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && dma_req));
  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !dma_req);
endmodule

// File: tb/tb_rx_frame_queue.sv
`timescale 1ns/1ps
module tb_rx_frame_queue;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_self = 0, self_rx_dis = 0, dma_mode = 0, irq_mask = 0;
  logic [31:0] in_cs = 0, in_id = 0, in_d0 = 0, in_d1 = 0;
  logic [7:0]  rd_addr = 0, wr_addr = 0;
  logic [31:0] rd_data, wr_data = 0;
  logic wr_en = 0, irq, dma_req;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_frame_queue dut (.clk, .rst_n, .in_valid, .in_cs, .in_id, .in_d0, .in_d1,
    .in_self, .self_rx_dis, .dma_mode, .irq_mask, .rd_addr, .rd_data,
    .wr_en, .wr_addr, .wr_data, .irq, .dma_req);

  // {in_self, self_rx_dis, identifier}
  localparam logic [33:0] VEC [6] = '{
    {1'b0, 1'b0, 32'h1234_5678},
    {1'b1, 1'b1, 32'h0000_0ABC},
    {1'b1, 1'b0, 32'h1FFF_FFFF},
    {1'b0, 1'b1, 32'h0000_0555},
    {1'b1, 1'b1, 32'h0ABC_DEF0},
    {1'b0, 1'b0, 32'h0000_0001}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(logic [31:0] id, logic self_f);
    in_valid = 1; in_self = self_f; in_id = id;
    in_cs = id ^ 32'hC5C5_0000; in_d0 = id + 1; in_d1 = ~id;
    @(negedge clk);
    in_valid = 0; in_self = 0;
  endtask

  task automatic wflag(logic [7:0] a, logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #0.5; d = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    rd(8'h00, v); check("R11 flags", v, 0);
    rd(8'h80, v); check("R11 head empty (R4)", v, 0);
    check("R11 irq", irq, 0);
    check("R11 dma_req", dma_req, 0);

    // table: self-reception filter and identifier storage
    irq_mask = 1;
    for (int i = 0; i < 6; i++) begin
      logic exp_st;
      exp_st = !(VEC[i][33] && VEC[i][32]);
      self_rx_dis = VEC[i][32];
      push(VEC[i][31:0], VEC[i][33]);
      rd(8'h00, v); check("R6 R1 available", v[0], exp_st);
      check("R6 irq", irq, exp_st);
      if (exp_st) begin
        rd(8'h84, v); check("R5 identifier", v, VEC[i][31:0]);
        wflag(8'h00, 1);
        rd(8'h00, v); check("R1 empty after release", v[0], 0);
      end
    end
    self_rx_dis = 0;

    // order, offsets, no-effect writes and reads
    push(32'hA1, 0); push(32'hA2, 0); push(32'hA3, 0);
    rd(8'h80, v); check("R4 cs", v, 32'hA1 ^ 32'hC5C5_0000);
    rd(8'h84, v); check("R4 id", v, 32'hA1);
    rd(8'h88, v); check("R4 d0", v, 32'hA2);
    rd(8'h8C, v); check("R4 d1", v, ~32'hA1);
    repeat (3) @(negedge clk);
    rd(8'h84, v); check("R3 reread", v, 32'hA1);
    wflag(8'h00, 0);
    rd(8'h84, v); check("R2 write 0 ignored", v, 32'hA1);
    wflag(8'h84, 1);
    rd(8'h84, v); check("R2 other offset ignored", v, 32'hA1);
    wflag(8'h00, 1);
    rd(8'h84, v); check("R2 R4 next head", v, 32'hA2);
    wflag(8'h00, 1);
    rd(8'h84, v); check("R4 third", v, 32'hA3);
    wflag(8'h00, 1);
    rd(8'h00, v); check("R1 drained", v, 0);
    wflag(8'h00, 1);
    rd(8'h00, v); check("R2 empty release ignored", v, 0);
    push(32'hB0, 0);
    rd(8'h84, v); check("R2 count not wrapped", v, 32'hB0);
    wflag(8'h00, 1);
    rd(8'h00, v); check("R2 single entry", v, 0);

    // fill, warn, overflow
    for (int i = 0; i < 4; i++) push(32'h100 + i, 0);
    rd(8'h00, v); check("R8 warn off at 4", v, 32'h1);
    push(32'h104, 0);
    rd(8'h00, v); check("R8 warn on at 5", v, 32'h3);
    push(32'h105, 0);
    rd(8'h00, v); check("R7 full no ovf", v, 32'h3);
    push(32'h106, 0); push(32'h107, 0);
    rd(8'h00, v); check("R7 ovf set", v, 32'h7);
    for (int i = 0; i < 6; i++) begin
      rd(8'h84, v); check("R7 kept order", v, 32'h100 + i);
      wflag(8'h00, 1);
    end
    rd(8'h00, v); check("R7 six kept, ovf sticky", v, 32'h4);
    wflag(8'h00, 4);
    rd(8'h00, v); check("R7 ovf cleared", v, 0);

    // interrupt vs DMA
    irq_mask = 0;
    push(32'hC1, 0);
    check("R9 masked irq", irq, 0);
    irq_mask = 1; #0.5;
    check("R9 irq", irq, 1);
    check("R10 no dma in irq mode", dma_req, 0);
    dma_mode = 1; irq_mask = 0; #0.5;
    check("R9 irq off in dma", irq, 0);
    check("R10 dma req", dma_req, 1);
    irq_mask = 1; #0.5;
    check("R9 mask ignored in dma", irq, 0);
    push(32'hC2, 0);
    wflag(8'h00, 1);
    check("R10 gap after release", dma_req, 0);
    @(negedge clk);
    check("R10 req back", dma_req, 1);
    rd(8'h84, v); check("R10 next head", v, 32'hC2);
    wflag(8'h00, 1);
    @(negedge clk);
    check("R10 empty no req", dma_req, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule